// File: doc/BRIEF.md
# Programmable Flash Instruction Sequencer

This block runs a transaction on a serial NOR flash that is described by a short program held in an internal table. The table holds 32 programs. Each program has eight 16-bit instruction slots. An instruction names a phase (command byte, address, dummy cycles, write data, read data or stop), the number of IO lines the phase uses (1, 2, 4 or 8), and an 8-bit operand.

Software fills the table through a simple word-write port. It then sends a start pulse together with a program index, a 32-bit flash address and a byte count. The sequencer holds chip select low, steps through the slots, and drives the IO lines with one beat per clock. The flash clock enable marks which cycles carry a beat. Write bytes come from a valid/ready byte stream. Each read byte is pushed out with a one-cycle valid strobe. When the program ends, a sticky done flag is raised, and software clears it by writing 1.

Top module: `flash_seq_engine`

## Requirements
- R1: The table holds 32 programs of four 32-bit words. The word index is program*4 + word. Slot 2k sits in bits [15:0] of word k and slot 2k+1 sits in bits [31:16]. In each slot, bits [15:10] are the opcode, bits [9:8] are the lane code and bits [7:0] are the operand. Writing one program leaves the other programs unchanged.
- R2: A start pulse is accepted only while `idle` is high. It latches the program index, the address and the byte count, and `idle` falls on the next cycle. A start pulse that arrives while busy is ignored, and so are changes to those inputs while busy.
- R3: `cs_n` is low from the cycle after an accepted start up to the end of the program. The program ends either at the decode of a STOP (opcode 0x00) or at the decode that follows slot 7. While idle there is no clock beat and no output enable.
- R4: Every slot costs one decode cycle with no beat. An unknown opcode, an address with operand 0, a dummy with operand 0, or a data phase with a byte count of 0 is skipped, and costs only that decode cycle.
- R5: Lane code c selects W = 2^c lines. On each beat, the next W most significant bits still to be sent are placed on lines W-1..0, with line 0 carrying the least significant of them. `io_oe` has its low W bits set and every unused line drives 0.
- R6: Opcode 0x01 sends the operand byte as a command, using 8/W beats.
- R7: Opcode 0x02 sends the low N bits of the latched address, where N is the operand limited to 32. This takes ceil(N/W) beats.
- R8: Opcode 0x0C produces min(operand, 64) beats with every output enable low.
- R9: Opcode 0x08 sends as many bytes as the latched count. Each byte takes one load cycle with `tx_ready` high and no beat, repeated while `tx_valid` is low, followed by 8/W beats of that byte.
- R10: Opcode 0x09 reads as many bytes as the latched count, with the outputs disabled. Each beat samples `io_in[W-1:0]` as the next less significant bits of the byte. Each byte takes 8/W beats, bytes follow one another with no gap, and `rx_valid` pulses for one cycle after the last beat of a byte, with the byte on `rx_data`.
- R11: `done_irq` sets in the cycle in which `idle` returns high. It then holds until a `done_clr` pulse clears it. If a clear and a finish happen in the same cycle, the set wins.
- R12: After synchronous reset, `idle`=1, `cs_n`=1, `done_irq`=0, `clk_en`=0, `io_oe`=0, `tx_ready`=0 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tbl_we | input | 1 | Table word write strobe |
| tbl_idx | input | 7 | Table word index (program*4 + word) |
| tbl_wdata | input | 32 | Table word: two instruction slots |
| start | input | 1 | Trigger pulse |
| seq_id | input | 5 | Program index to run |
| flash_addr | input | 32 | Address used by address phases |
| byte_cnt | input | 16 | Byte count used by data phases |
| idle | output | 1 | Ready to accept a trigger |
| done_irq | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Write-1 clear of the completion flag |
| cs_n | output | 1 | Flash chip select, active low |
| clk_en | output | 1 | Flash clock beat in this cycle |
| io_out | output | 8 | Data driven on the IO lines |
| io_oe | output | 8 | Per-line output enable |
| io_in | input | 8 | Data sampled from the IO lines |
| tx_data | input | 8 | Write byte |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Write byte taken this cycle when valid |
| rx_data | output | 8 | Read byte |
| rx_valid | output | 1 | Read byte strobe |

## Verification
The cycle timing is fixed, so the bench's reference model turns each program into a list of expected per-cycle records, starting with the cycle right after the accepted start. Each record gives one decode cycle, command, address, write and dummy beats, load cycles (with any stall cycles added), and read beats. Every falling edge is compared against one record. A read byte is expected on `rx_valid` exactly one record after the beat that completed it. `cs_n`, `idle` and `done_irq` are expected one cycle after the finishing decode record. The bench changes inputs only after it has compared the outputs, so what it drives lands at the next rising edge.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the flash instruction sequencer: opcodes,
// instruction word layout, controller states and lane helpers.
package flash_seq_pkg;

    localparam logic [5:0] OP_STOP  = 6'h00;
    localparam logic [5:0] OP_CMD   = 6'h01;
    localparam logic [5:0] OP_ADDR  = 6'h02;
    localparam logic [5:0] OP_WRITE = 6'h08;
    localparam logic [5:0] OP_READ  = 6'h09;
    localparam logic [5:0] OP_DUMMY = 6'h0C;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] lanes;
        logic [7:0] arg;
    } seq_instr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEC, ST_SHIFT, ST_DUMMY, ST_WLOAD, ST_RD
    } seq_state_t;

    // Number of active lines for a lane code.
    function automatic logic [3:0] lane_width(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // Enable mask covering the active lines for a lane code.
    function automatic logic [7:0] lane_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 8'h01;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/seq_table.sv
`timescale 1ns/1ps
// Instruction table. It has one write port for 32-bit words and one
// combinational read port that returns a single 16-bit slot. It assumes
// that a word holds two slots, with the even slot in the low half.
module seq_table
    import flash_seq_pkg::*;
#(
    parameter int NUM_SEQ = 32,
    parameter int SLOTS   = 8,
    localparam int WORDS  = SLOTS / 2,
    localparam int SEQ_W  = $clog2(NUM_SEQ),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int IDX_W  = $clog2(NUM_SEQ * WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [SEQ_W-1:0]  rd_seq,
    input  logic [SLOT_W-1:0] rd_slot,
    output seq_instr_t        rd_instr
);
    logic [31:0] mem [NUM_SEQ * WORDS];
    logic [31:0] word;
    logic [15:0] half [2];

    // Store a table word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Select the word that holds the requested slot.
    always_comb word = mem[{rd_seq, rd_slot[SLOT_W-1:1]}];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half[h] = word[16*h +: 16];
    end

    // Select the slot within the word.
    always_comb rd_instr = seq_instr_t'(half[rd_slot[0]]);
endmodule

// File: rtl/lane_shifter.sv
`timescale 1ns/1ps
// Beat datapath. It shifts outgoing bits MSB first from a 32-bit
// register and gathers incoming bits into a byte. It assumes that the
// lane width divides 8 for byte transfers.
module lane_shifter
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        shift_out,
    input  logic        shift_in,
    input  logic [1:0]  lanes,
    input  logic [7:0]  io_in,
    output logic [7:0]  beat_bits,
    output logic [7:0]  rx_byte
);
    logic [31:0] sr;
    logic [7:0]  rb;
    logic [3:0]  width;
    logic [7:0]  mask;

    always_comb width = lane_width(lanes);
    always_comb mask  = lane_mask(lanes);

    // Load or advance the outgoing register, and collect incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
            rb <= '0;
        end else begin
            if (load)           sr <= load_val;
            else if (shift_out) sr <= sr << width;
            if (shift_in)       rb <= (rb << width) | (io_in & mask);
        end
    end

    // The top W bits of the register, placed on lines W-1..0.
    always_comb beat_bits = (sr[31:24] >> (4'd8 - width)) & mask;
    always_comb rx_byte   = rb;
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer control. It latches a trigger, walks the slots of one program,
// counts bits, bytes and dummy cycles, and owns the done flag. It assumes
// a one-cycle decode for every slot and one beat per clock.
module seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int NUM_SEQ = 32,
    parameter int SLOTS   = 8,
    parameter int CNT_W   = 16,
    localparam int SEQ_W  = $clog2(NUM_SEQ),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SEQ_W-1:0]  seq_id,
    input  logic [31:0]       flash_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              done_clr,
    input  seq_instr_t        instr,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic [SEQ_W-1:0]  cur_seq,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              load,
    output logic [31:0]       load_val,
    output logic              shift_out,
    output logic              shift_in,
    output logic [1:0]        lanes,
    output logic              idle,
    output logic              cs_n,
    output logic              beat,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic              done
);
    localparam logic [SLOT_W:0] SLOT_ONE = 1;
    localparam logic [SLOT_W:0] SLOT_END = SLOTS[SLOT_W:0];
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    seq_state_t        st;
    logic [31:0]       addr_q;
    logic [CNT_W-1:0]  cnt_q, left_q;
    logic [SLOT_W:0]   slot_q;
    logic [5:0]        bits_q;
    logic [6:0]        dcnt_q;
    logic [5:0]        op_q;
    logic              rxv_q, done_q;
    logic [3:0]        width;
    logic              last_bits, finish;
    logic [5:0]        addr_n;
    logic [6:0]        dummy_n;

    // Operand limits, and the end of the current byte or field.
    always_comb begin
        width     = lane_width(lanes);
        last_bits = bits_q <= {2'b00, width};
        addr_n    = (instr.arg > 8'd32) ? 6'd32 : instr.arg[5:0];
        dummy_n   = (instr.arg > 8'd64) ? 7'd64 : instr.arg[6:0];
        finish    = (st == ST_DEC) && ((slot_q == SLOT_END) || (instr.op == OP_STOP));
    end

    // Preload value for the outgoing shift register.
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        if (st == ST_DEC && !finish && instr.op == OP_CMD) begin
            load     = 1'b1;
            load_val = {instr.arg, 24'h0};
        end else if (st == ST_DEC && !finish && instr.op == OP_ADDR && addr_n != 6'd0) begin
            load     = 1'b1;
            load_val = addr_q << (6'd32 - addr_n);
        end else if (st == ST_WLOAD && tx_valid) begin
            load     = 1'b1;
            load_val = {tx_data, 24'h0};
        end
    end

    // Strobes and status that follow from the state.
    always_comb begin
        shift_out = (st == ST_SHIFT);
        shift_in  = (st == ST_RD);
        beat      = (st == ST_SHIFT) || (st == ST_DUMMY) || (st == ST_RD);
        tx_ready  = (st == ST_WLOAD);
        idle      = (st == ST_IDLE);
        cs_n      = (st == ST_IDLE);
        cur_slot  = slot_q[SLOT_W-1:0];
        rx_valid  = rxv_q;
        done      = done_q;
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cur_seq <= '0;
            addr_q  <= '0;
            cnt_q   <= '0;
            left_q  <= '0;
            slot_q  <= '0;
            bits_q  <= '0;
            dcnt_q  <= '0;
            op_q    <= OP_STOP;
            lanes   <= 2'd0;
            rxv_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            rxv_q  <= (st == ST_RD) && last_bits;
            done_q <= finish || (done_q && !done_clr);
            case (st)
                ST_IDLE: if (start) begin
                    cur_seq <= seq_id;
                    addr_q  <= flash_addr;
                    cnt_q   <= byte_cnt;
                    slot_q  <= '0;
                    st      <= ST_DEC;
                end
                ST_DEC: begin
                    lanes <= instr.lanes;
                    op_q  <= instr.op;
                    if (finish) st <= ST_IDLE;
                    else case (instr.op)
                        OP_CMD: begin
                            bits_q <= 6'd8;
                            st     <= ST_SHIFT;
                        end
                        OP_ADDR: if (addr_n == 6'd0) slot_q <= slot_q + SLOT_ONE;
                                 else begin bits_q <= addr_n; st <= ST_SHIFT; end
                        OP_DUMMY: if (dummy_n == 7'd0) slot_q <= slot_q + SLOT_ONE;
                                  else begin dcnt_q <= dummy_n; st <= ST_DUMMY; end
                        OP_WRITE: if (cnt_q == '0) slot_q <= slot_q + SLOT_ONE;
                                  else begin left_q <= cnt_q; st <= ST_WLOAD; end
                        OP_READ: if (cnt_q == '0) slot_q <= slot_q + SLOT_ONE;
                                 else begin left_q <= cnt_q; bits_q <= 6'd8; st <= ST_RD; end
                        default: slot_q <= slot_q + SLOT_ONE;
                    endcase
                end
                ST_SHIFT: begin
                    bits_q <= bits_q - {2'b00, width};
                    if (last_bits) begin
                        if (op_q == OP_WRITE && left_q > CNT_ONE) begin
                            left_q <= left_q - CNT_ONE;
                            st     <= ST_WLOAD;
                        end else begin
                            slot_q <= slot_q + SLOT_ONE;
                            st     <= ST_DEC;
                        end
                    end
                end
                ST_WLOAD: if (tx_valid) begin
                    bits_q <= 6'd8;
                    st     <= ST_SHIFT;
                end
                ST_DUMMY: begin
                    dcnt_q <= dcnt_q - 7'd1;
                    if (dcnt_q == 7'd1) begin
                        slot_q <= slot_q + SLOT_ONE;
                        st     <= ST_DEC;
                    end
                end
                ST_RD: begin
                    if (!last_bits) bits_q <= bits_q - {2'b00, width};
                    else if (left_q > CNT_ONE) begin
                        left_q <= left_q - CNT_ONE;
                        bits_q <= 6'd8;
                    end else begin
                        slot_q <= slot_q + SLOT_ONE;
                        st     <= ST_DEC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_engine.sv
`timescale 1ns/1ps
// Top of the flash instruction sequencer. It connects the table, the
// control state machine and the beat datapath, and gates the IO outputs
// to the active lines of beats that drive data.
module flash_seq_engine
    import flash_seq_pkg::*;
#(
    parameter int NUM_SEQ  = 32,
    parameter int SLOTS    = 8,
    parameter int CNT_W    = 16,
    localparam int SEQ_W   = $clog2(NUM_SEQ),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int TBL_IDX_W = $clog2(NUM_SEQ * SLOTS / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_we,
    input  logic [TBL_IDX_W-1:0] tbl_idx,
    input  logic [31:0]          tbl_wdata,
    input  logic                 start,
    input  logic [SEQ_W-1:0]     seq_id,
    input  logic [31:0]          flash_addr,
    input  logic [CNT_W-1:0]     byte_cnt,
    output logic                 idle,
    output logic                 done_irq,
    input  logic                 done_clr,
    output logic                 cs_n,
    output logic                 clk_en,
    output logic [7:0]           io_out,
    output logic [7:0]           io_oe,
    input  logic [7:0]           io_in,
    input  logic [7:0]           tx_data,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    output logic [7:0]           rx_data,
    output logic                 rx_valid
);
    seq_instr_t        instr;
    logic [SEQ_W-1:0]  cur_seq;
    logic [SLOT_W-1:0] cur_slot;
    logic              load, shift_out, shift_in;
    logic [31:0]       load_val;
    logic [1:0]        lanes;
    logic [7:0]        beat_bits;

    seq_table #(.NUM_SEQ(NUM_SEQ), .SLOTS(SLOTS)) u_table (
        .clk(clk), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_data(tbl_wdata),
        .rd_seq(cur_seq), .rd_slot(cur_slot), .rd_instr(instr)
    );

    seq_ctrl #(.NUM_SEQ(NUM_SEQ), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .seq_id(seq_id),
        .flash_addr(flash_addr), .byte_cnt(byte_cnt), .done_clr(done_clr),
        .instr(instr), .tx_data(tx_data), .tx_valid(tx_valid),
        .cur_seq(cur_seq), .cur_slot(cur_slot), .load(load), .load_val(load_val),
        .shift_out(shift_out), .shift_in(shift_in), .lanes(lanes),
        .idle(idle), .cs_n(cs_n), .beat(clk_en), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .done(done_irq)
    );

    lane_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .shift_out(shift_out), .shift_in(shift_in), .lanes(lanes),
        .io_in(io_in), .beat_bits(beat_bits), .rx_byte(rx_data)
    );

    // Drive only the active lines, and only during beats that send data.
    always_comb begin
        io_oe  = shift_out ? lane_mask(lanes) : 8'h00;
        io_out = shift_out ? beat_bits : 8'h00;
    end
endmodule

// File: rtl/flash_seq_engine_chk.sv
`timescale 1ns/1ps
// Temporal checks on the sequencer's ports, bound to the top module.
module flash_seq_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       idle,
    input logic       done_irq,
    input logic       done_clr,
    input logic       cs_n,
    input logic       clk_en,
    input logic [7:0] io_oe,
    input logic       tx_ready,
    input logic       rx_valid
);
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        idle && start |=> !idle);                                          // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> cs_n && !clk_en && io_oe == 8'h00);                       // R3
    AST_OE_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe != 8'h00 |-> clk_en && !cs_n);                               // R5
    AST_LOAD_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !clk_en && io_oe == 8'h00);                           // R9
    AST_RX_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(clk_en) && $past(io_oe) == 8'h00);              // R10
    AST_FINISH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> done_irq);                                         // R11
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !start && done_clr |=> !done_irq);                         // R11
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq && !done_clr |=> done_irq);                               // R11
endmodule

bind flash_seq_engine flash_seq_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done_irq(done_irq),
    .done_clr(done_clr), .cs_n(cs_n), .clk_en(clk_en), .io_oe(io_oe),
    .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/test_flash_seq_engine.sv
`timescale 1ns/1ps
module test_flash_seq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_idx = '0;
    logic [31:0] tbl_wdata = '0;
    logic        start = 1'b0;
    logic [4:0]  seq_id = '0;
    logic [31:0] flash_addr = '0;
    logic [15:0] byte_cnt = '0;
    logic        done_clr = 1'b0;
    logic [7:0]  io_in = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b1;
    logic        idle, done_irq, cs_n, clk_en, tx_ready, rx_valid;
    logic [7:0]  io_out, io_oe, rx_data;

    always #4 clk = ~clk;

    flash_seq_engine i_flash_seq_engine (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_wdata(tbl_wdata), .start(start), .seq_id(seq_id),
        .flash_addr(flash_addr), .byte_cnt(byte_cnt), .idle(idle),
        .done_irq(done_irq), .done_clr(done_clr), .cs_n(cs_n), .clk_en(clk_en),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    typedef struct {
        bit       beat;
        bit [7:0] oe;
        bit [7:0] out;
        bit       txr;
        bit       rd;
        int       w;
        string    tag;
    } rec_t;

    rec_t        q[$];
    logic [15:0] prog [8];
    logic [7:0]  txb [16];
    int          checks = 0;
    int          fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input int op, input int lc, input int arg);
        return {6'(op), 2'(lc), 8'(arg)};
    endfunction

    function automatic void push(input bit beat, input bit [7:0] oe, input bit [7:0] out,
                                 input bit txr, input bit rd, input int w, input string tag);
        rec_t r;
        r.beat = beat; r.oe = oe; r.out = out; r.txr = txr; r.rd = rd; r.w = w; r.tag = tag;
        q.push_back(r);
    endfunction

    // Beats of a field sent MSB first, W bits per beat, line 0 = LSB (R5).
    function automatic void beats(input logic [31:0] val, input int bits, input int w,
                                  input string tag);
        logic [31:0] v = val;
        bit [7:0] m = 8'((1 << w) - 1);
        for (int k = 0; k < (bits + w - 1) / w; k++) begin
            push(1, m, 8'(v >> (32 - w)) & m, 0, 0, 0, tag);
            v = v << w;
        end
    endfunction

    // Reference model: per-cycle records from the cycle after the start.
    function automatic void build(input logic [31:0] addr, input int cnt, input int stall);
        int op, lc, w, arg, n;
        bit stopped = 0;
        q.delete();
        for (int s = 0; s < 8 && !stopped; s++) begin
            push(0, 0, 0, 0, 0, 0, "R4 decode");
            op = int'(prog[s][15:10]); lc = int'(prog[s][9:8]);
            arg = int'(prog[s][7:0]); w = 1 << lc;
            case (op)
                0:  stopped = 1;
                1:  beats({8'(arg), 24'h0}, 8, w, "R6 R5 command");
                2:  begin
                        n = (arg > 32) ? 32 : arg;
                        if (n > 0) beats(addr << (32 - n), n, w, "R7 R5 address");
                    end
                12: begin
                        n = (arg > 64) ? 64 : arg;
                        for (int k = 0; k < n; k++) push(1, 0, 0, 0, 0, 0, "R8 dummy");
                    end
                8:  for (int b = 0; b < cnt; b++) begin
                        if (b == 0)
                            for (int k = 0; k < stall; k++) push(0, 0, 0, 1, 0, 0, "R9 stall");
                        push(0, 0, 0, 1, 0, 0, "R9 load");
                        beats({txb[b], 24'h0}, 8, w, "R9 R5 write");
                    end
                9:  for (int b = 0; b < cnt * (8 / w); b++) push(1, 0, 0, 0, 1, w, "R10 read");
                default: ;
            endcase
        end
        if (!stopped) push(0, 0, 0, 0, 0, 0, "R3 end after slot 7");
    endfunction

    // Write the current program into table entry 'seq' (R1 layout).
    task automatic load_prog(input int seq);
        for (int k = 0; k < 4; k++) begin
            tbl_we = 1'b1; tbl_idx = 7'(seq * 4 + k);
            tbl_wdata = {prog[2*k+1], prog[2*k]};
            @(negedge clk);
        end
        tbl_we = 1'b0;
    endtask

    task automatic run(input int seq, input logic [31:0] addr, input int cnt, input int stall,
                       input int busy_at, input bit clr_last);
        int tx_ptr = 0, stall_left = stall, nbits = 0;
        bit pend = 0, rx_exp = 0, rx_next;
        logic [7:0] acc = 0, rx_byte = 0, v;
        build(addr, cnt, stall);
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        start = 1'b1; seq_id = 5'(seq); flash_addr = addr; byte_cnt = 16'(cnt);
        tx_valid = 1'b1; tx_data = txb[0];
        @(negedge clk);
        start = 1'b0;
        foreach (q[i]) begin
            chk({cs_n, idle, clk_en, io_oe, io_out, tx_ready} ==
                {1'b0, 1'b0, q[i].beat, q[i].oe, q[i].out, q[i].txr},
                q[i].tag, $sformatf("record %0d", i),
                {cs_n, idle, clk_en, io_oe, io_out, tx_ready},
                {1'b0, 1'b0, q[i].beat, q[i].oe, q[i].out, q[i].txr});
            chk(rx_valid == rx_exp, "R10", "rx_valid", rx_valid, rx_exp);
            if (rx_exp) chk(rx_data == rx_byte, "R10", "rx_data", rx_data, rx_byte);
            // R2: a trigger while busy, with new operands, must have no effect.
            start = (i == busy_at);
            if (i == busy_at) begin
                seq_id = 5'd17; flash_addr = 32'hFFFF_0000; byte_cnt = 16'd9;
            end
            done_clr = clr_last && (i == q.size() - 1);
            if (pend) tx_ptr++;
            if (tx_ready && stall_left > 0) begin tx_valid = 1'b0; stall_left--; end
            else tx_valid = 1'b1;
            tx_data = txb[tx_ptr];
            pend = tx_ready && tx_valid;
            rx_next = 0;
            if (q[i].rd) begin
                v = 8'(i * 29 + 7);
                io_in = v;
                acc = 8'((acc << q[i].w) | (v & 8'((1 << q[i].w) - 1)));
                nbits += q[i].w;
                if (nbits == 8) begin rx_next = 1; rx_byte = acc; nbits = 0; acc = 0; end
            end
            rx_exp = rx_next;
            @(negedge clk);
        end
        start = 1'b0; done_clr = 1'b0;
        chk({cs_n, idle, done_irq, clk_en} == 4'b1110, "R3 R11", "finish state",
            {cs_n, idle, done_irq, clk_en}, 4'b1110);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) txb[k] = 8'(k * 53 + 17);
        repeat (3) @(negedge clk);
        // R12 reset values
        chk({idle, cs_n, done_irq, clk_en, io_oe, tx_ready, rx_valid} == 14'b11_0_0_00000000_0_0,
            "R12", "reset outputs",
            {idle, cs_n, done_irq, clk_en, io_oe, tx_ready, rx_valid}, 14'b11000000000000);
        rst_n = 1'b1;
        @(negedge clk);

        // Program 3: 1-line command, 24-bit address, 1-line read, stop.
        foreach (prog[k]) prog[k] = 16'h0;
        prog[0] = ins(1, 0, 8'h9F); prog[1] = ins(2, 0, 24); prog[2] = ins(9, 0, 0);
        load_prog(3);
        // R2 busy trigger ignored; R11 finish wins over a same-cycle clear.
        run(3, 32'h00A5_C3E1, 2, 0, 5, 1);
        repeat (3) @(negedge clk);
        chk(done_irq == 1'b1, "R11", "done holds", done_irq, 1);
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        chk(done_irq == 1'b0, "R11", "done cleared", done_irq, 0);

        // Program 31: octal command, quad 32-bit address, dummy clamp, quad read.
        foreach (prog[k]) prog[k] = 16'h0;
        prog[0] = ins(1, 3, 8'hEB); prog[1] = ins(2, 2, 32);
        prog[2] = ins(12, 2, 100);  prog[3] = ins(9, 2, 0);
        load_prog(31);
        run(31, 32'h1234_ABCD, 3, 0, -1, 0);

        // Program 0: no stop; skipped slots, dual write, octal read, mixed.
        prog[0] = ins(1, 1, 8'h3B); prog[1] = ins(2, 0, 0);  prog[2] = ins(8'h3F, 1, 5);
        prog[3] = ins(12, 0, 0);    prog[4] = ins(8, 1, 0);  prog[5] = ins(9, 3, 0);
        prog[6] = ins(1, 0, 8'h05); prog[7] = ins(2, 3, 16);
        load_prog(0);
        run(0, 32'h0000_BEEF, 3, 0, -1, 0);

        // Program 17: address clamp to 32 bits, quad write with source stall.
        foreach (prog[k]) prog[k] = 16'h0;
        prog[0] = ins(1, 2, 8'h32); prog[1] = ins(2, 0, 40); prog[2] = ins(8, 2, 0);
        load_prog(17);
        run(17, 32'h8001_7F3C, 2, 3, -1, 0);

        // Program with zero byte count: data phase skipped (R4).
        run(17, 32'h0000_0011, 0, 0, -1, 0);

        // R1: program 3 survives writes to other entries.
        foreach (prog[k]) prog[k] = 16'h0;
        prog[0] = ins(1, 0, 8'h9F); prog[1] = ins(2, 0, 24); prog[2] = ins(9, 0, 0);
        run(3, 32'h0055_AA33, 1, 0, -1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule